// File: doc/BRIEF.md
# OSD Register Write Command Parser

This block turns an already deserialized byte stream from a serial front end into write requests for an on-screen-display register memory of 16 rows by 32 columns. It recognises row-address bytes, column-address bytes and data bytes. It supports three packet formats. In the first, every data byte is preceded by a new row and column. In the second, only a new column precedes each data byte. In the third, the data stream is continuous and the location advances by itself. A packet-start strobe and a packet-end strobe (chip-select edges or START/STOP conditions) frame each packet.

Each accepted data byte becomes one write request carrying row, column, a plane flag (character-code plane or attribute plane) and the data byte. While the pixel clock PLL is unlocked, the block drops writes everywhere except a small set of control locations on the last row, because those are the only locations that are safe to write in that condition.

The input and output are both valid/ready streams. A byte is consumed on a clock edge where `in_valid` and `in_ready` are both high. The write request is registered. It stays asserted, with all of its fields unchanged, until the edge where `wr_ready` is high. While a request is held, `in_ready` is low, so back-pressure passes straight through to the byte source with no byte lost or duplicated. The packet strobes are plain controls that act on the edge where they are high, whether or not a byte is transferred.

Top module: `osd_cmd_parser`

## Requirements
- R1: A byte with bit 7 set, accepted where an address is expected, is a row byte. Bits 3:0 select the row, and bit 5 selects the attribute plane (1) or the character-code plane (0).
- R2: A byte with bit 7 clear, accepted after a row byte or after a data byte of the first two formats, is a column byte. Bits 4:0 select the column, and bit 6 set enters streaming format.
- R3: Between packets the parser waits for a row byte. Any other byte in that state produces no write and leaves the parser waiting.
- R4: After a data byte outside streaming format, either a row byte (first format) or a column byte (second format) may follow, and the two may be mixed freely within one packet.
- R5: Once streaming format is entered, every further byte of the packet is a data byte, including bytes with bit 7 set.
- R6: In streaming format, the first data byte goes to the addressed location and each later one goes to the next column. Column 31 wraps to column 0 of the next row, and row 15 wraps to row 0.
- R7: `pkt_end` returns the parser to the waiting state. A byte accepted on the same edge is still handled as the last byte of the packet.
- R8: `pkt_start` abandons any partial packet. A byte accepted on the same edge is handled as the first byte of a new packet.
- R9: While `pll_locked` is low, only writes to row 15, columns 15, 17 and 18 are issued, and all other data bytes are dropped. The addressing and the streaming advance still proceed.
- R10: Each issued write appears as `wr_valid` one edge after its byte is accepted. It is held, with row, column, plane and data stable, until an edge with `wr_ready` high, and `in_ready` is low while it is held.
- R11: After reset no write is pending, `in_ready` is high and the parser waits for a row byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Parser can take a byte this cycle |
| in_data | input | 8 | Deserialized command byte |
| pkt_start | input | 1 | Packet start strobe |
| pkt_end | input | 1 | Packet end strobe |
| pll_locked | input | 1 | Pixel clock PLL lock indication |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Memory accepts the pending write |
| wr_row | output | 4 | Write row |
| wr_col | output | 5 | Write column |
| wr_attr | output | 1 | 1 selects the attribute plane, 0 the character-code plane |
| wr_data | output | 8 | Write data |

## Verification
Two sets of events can fall in the same cycle, and each is provoked on purpose.

The first pair is a packet strobe and a byte transfer. The last data byte is sent with `pkt_end` high on the same edge, and the bench expects that write to be issued and the following column-like bytes to be ignored. A byte is also sent with `pkt_start` high while a partial packet is pending, and the bench expects it to be decoded from the waiting state rather than as data.

The second pair is the draining of a held write and the acceptance of the next streaming byte. The byte is kept on the input while `wr_ready` is low. When `wr_ready` rises, the old write leaves and the new byte enters on the same edge. The bench judges this by the exact sequence of writes, with neither a loss nor a repeat.

// File: rtl/osd_parser_pkg.sv
package osd_parser_pkg;

  // Bit positions inside a command byte; the decode depends on them.
  localparam int BIT_ADDR_ROW = 7;
  localparam int BIT_STREAM   = 6;
  localparam int BIT_PLANE    = 5;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,   // waiting for a row byte
    PS_COL    = 2'd1,   // row or column byte expected
    PS_DATA   = 2'd2,   // single data byte expected
    PS_STREAM = 2'd3    // every byte is data, address auto-advances
  } parse_state_e;

  typedef enum logic [1:0] {
    BK_IGNORE = 2'd0,
    BK_ROW    = 2'd1,
    BK_COL    = 2'd2,
    BK_DATA   = 2'd3
  } byte_kind_e;

endpackage

// File: rtl/osd_byte_decode.sv
module osd_byte_decode
  import osd_parser_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  parse_state_e       state,
  input  logic [DATA_W-1:0]  byte_in,
  output byte_kind_e         kind,
  output logic [ROW_W-1:0]   row_f,
  output logic [COL_W-1:0]   col_f,
  output logic               plane_f,
  output logic               stream_f
);

  logic addr_is_row;

  assign addr_is_row = byte_in[BIT_ADDR_ROW];
  assign row_f       = byte_in[ROW_W-1:0];
  assign col_f       = byte_in[COL_W-1:0];
  assign plane_f     = byte_in[BIT_PLANE];
  assign stream_f    = byte_in[BIT_STREAM];

  always_comb begin
    case (state)
      PS_IDLE:   kind = addr_is_row ? BK_ROW : BK_IGNORE;
      PS_COL:    kind = addr_is_row ? BK_ROW : BK_COL;
      PS_DATA:   kind = BK_DATA;
      PS_STREAM: kind = BK_DATA;
      default:   kind = BK_IGNORE;
    endcase
  end

endmodule

// File: rtl/osd_addr_track.sv
module osd_addr_track
  import osd_parser_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  byte_kind_e        kind,
  input  logic [ROW_W-1:0]  row_f,
  input  logic [COL_W-1:0]  col_f,
  input  logic              plane_f,
  input  logic              stream_f,
  output parse_state_e      state_q,
  output parse_state_e      eff_state,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              plane_q
);

  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  parse_state_e      st_n;
  logic [ROW_W-1:0]  row_n;
  logic [COL_W-1:0]  col_n;
  logic              plane_n;

  // A start strobe clears the packet before its own byte is decoded.
  assign eff_state = pkt_start ? PS_IDLE : state_q;

  always_comb begin
    st_n    = eff_state;
    row_n   = row_q;
    col_n   = col_q;
    plane_n = plane_q;
    if (take) begin
      case (kind)
        BK_ROW: begin
          row_n   = row_f;
          plane_n = plane_f;
          st_n    = PS_COL;
        end
        BK_COL: begin
          col_n = col_f;
          st_n  = stream_f ? PS_STREAM : PS_DATA;
        end
        BK_DATA: begin
          if (eff_state == PS_STREAM) begin
            col_n = col_q + COL_ONE;
            if (&col_q) row_n = row_q + ROW_ONE;
          end else begin
            st_n = PS_COL;
          end
        end
        default: ;
      endcase
    end
    if (pkt_end) st_n = PS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      plane_q <= 1'b0;
    end else begin
      state_q <= st_n;
      row_q   <= row_n;
      col_q   <= col_n;
      plane_q <= plane_n;
    end
  end

endmodule

// File: rtl/osd_write_gate.sv
module osd_write_gate #(
  parameter int                     ROW_W         = 4,
  parameter int                     COL_W         = 5,
  parameter int                     DATA_W        = 8,
  parameter int                     LOCK_ROW      = 15,
  parameter logic [(2**COL_W)-1:0]  LOCK_COL_MASK = 32'h0006_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              pll_locked,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              plane,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_ready,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_attr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int               NCOLS     = 2**COL_W;
  localparam logic [ROW_W-1:0] LOCK_ROWV = ROW_W'(LOCK_ROW);

  logic [NCOLS-1:0] safe_col;
  logic             allowed;
  logic             issue;

  for (genvar c = 0; c < NCOLS; c++) begin : g_safe
    assign safe_col[c] = LOCK_COL_MASK[c];
  end

  assign allowed  = pll_locked || ((row == LOCK_ROWV) && safe_col[col]);
  assign issue    = fire && allowed;
  assign in_ready = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_attr  <= 1'b0;
      wr_data  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_row   <= row;
      wr_col   <= col;
      wr_attr  <= plane;
      wr_data  <= data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/osd_cmd_parser.sv
module osd_cmd_parser
  import osd_parser_pkg::*;
#(
  parameter int                     ROW_W         = 4,
  parameter int                     COL_W         = 5,
  parameter int                     DATA_W        = 8,
  parameter int                     LOCK_ROW      = 15,
  parameter logic [(2**COL_W)-1:0]  LOCK_COL_MASK = 32'h0006_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              pll_locked,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_attr,
  output logic [DATA_W-1:0] wr_data
);

  parse_state_e      state_q;
  parse_state_e      eff_state;
  byte_kind_e        kind;
  logic [ROW_W-1:0]  row_f;
  logic [COL_W-1:0]  col_f;
  logic              plane_f;
  logic              stream_f;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_plane;
  logic              take;
  logic              fire;

  assign take = in_valid && in_ready;
  assign fire = take && (kind == BK_DATA);

  osd_byte_decode #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_decode (
    .state    (eff_state),
    .byte_in  (in_data),
    .kind     (kind),
    .row_f    (row_f),
    .col_f    (col_f),
    .plane_f  (plane_f),
    .stream_f (stream_f)
  );

  osd_addr_track #(
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .pkt_start (pkt_start),
    .pkt_end   (pkt_end),
    .kind      (kind),
    .row_f     (row_f),
    .col_f     (col_f),
    .plane_f   (plane_f),
    .stream_f  (stream_f),
    .state_q   (state_q),
    .eff_state (eff_state),
    .row_q     (cur_row),
    .col_q     (cur_col),
    .plane_q   (cur_plane)
  );

  osd_write_gate #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .LOCK_ROW(LOCK_ROW), .LOCK_COL_MASK(LOCK_COL_MASK)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .pll_locked (pll_locked),
    .row        (cur_row),
    .col        (cur_col),
    .plane      (cur_plane),
    .data       (in_data),
    .wr_ready   (wr_ready),
    .in_ready   (in_ready),
    .wr_valid   (wr_valid),
    .wr_row     (wr_row),
    .wr_col     (wr_col),
    .wr_attr    (wr_attr),
    .wr_data    (wr_data)
  );

endmodule

// File: rtl/osd_cmd_parser_chk.sv
module osd_cmd_parser_chk
  import osd_parser_pkg::*;
#(
  parameter int                     ROW_W         = 4,
  parameter int                     COL_W         = 5,
  parameter int                     DATA_W        = 8,
  parameter int                     LOCK_ROW      = 15,
  parameter logic [(2**COL_W)-1:0]  LOCK_COL_MASK = 32'h0006_8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pkt_start,
  input logic              pkt_end,
  input logic              pll_locked,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic              wr_attr,
  input logic [DATA_W-1:0] wr_data,
  input parse_state_e      state_q,
  input logic [COL_W-1:0]  cur_col
);

  localparam logic [COL_W-1:0] COL_ONE   = COL_W'(1);
  localparam logic [ROW_W-1:0] LOCK_ROWV = ROW_W'(LOCK_ROW);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_row) && $stable(wr_col)
                                 && $stable(wr_attr) && $stable(wr_data)));

  a_r10_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready);

  a_r7_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (state_q == PS_IDLE));

  a_r9_unlocked_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pll_locked) |=>
      (!wr_valid || ((wr_row == LOCK_ROWV) && LOCK_COL_MASK[wr_col])));

  a_r6_stream_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pkt_start && (state_q == PS_STREAM)) |=>
      (cur_col == $past(cur_col) + COL_ONE));

  a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_IDLE) && !pkt_start && in_ready) |=> !wr_valid);

endmodule

bind osd_cmd_parser osd_cmd_parser_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
  .LOCK_ROW(LOCK_ROW), .LOCK_COL_MASK(LOCK_COL_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pkt_start  (pkt_start),
  .pkt_end    (pkt_end),
  .pll_locked (pll_locked),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_row     (wr_row),
  .wr_col     (wr_col),
  .wr_attr    (wr_attr),
  .wr_data    (wr_data),
  .state_q    (state_q),
  .cur_col    (cur_col)
);

// File: tb/osd_cmd_parser_tb.sv
module osd_cmd_parser_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       pkt_start = 1'b0;
  logic       pkt_end = 1'b0;
  logic       pll_locked = 1'b1;
  logic       wr_valid;
  logic       wr_ready = 1'b1;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic       wr_attr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;

  logic [17:0] got_q[$];
  logic [17:0] exp_q[$];

  always #5 clk = ~clk;

  osd_cmd_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .pll_locked(pll_locked), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_row(wr_row), .wr_col(wr_col), .wr_attr(wr_attr), .wr_data(wr_data)
  );

  // A write is transferred on the edge that follows a negedge with valid and ready.
  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready) got_q.push_back({wr_row, wr_col, wr_attr, wr_data});

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic st, input logic en);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; pkt_start = st; pkt_end = en;
    @(posedge clk);
  endtask

  task automatic send_end();
    @(negedge clk);
    in_valid = 1'b0; pkt_start = 1'b0; pkt_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_end = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; pkt_start = 1'b0; pkt_end = 1'b0;
  endtask

  task automatic expect_wr(input int r, input int c, input int a, input int d);
    exp_q.push_back({4'(r), 5'(c), 1'(a), 8'(d)});
  endtask

  task automatic check_writes(input string req);
    repeat (3) @(negedge clk);
    check(got_q.size() == exp_q.size(), req, "write count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, "write {row,col,attr,data}", got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(wr_valid == 1'b0, "R11", "wr_valid after reset", wr_valid, 0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
  endtask

  // R1 R4: format (a), row byte before every column/data pair, both planes
  task automatic t_format_a();
    send_byte(8'h82, 1, 0); send_byte(8'h05, 0, 0); send_byte(8'h41, 0, 0);
    send_byte(8'hA3, 0, 0); send_byte(8'h10, 0, 0); send_byte(8'h77, 0, 0);
    send_end();
    expect_wr(2, 5, 0, 8'h41);
    expect_wr(3, 16, 1, 8'h77);
    check_writes("R1");
  endtask

  // R2 R4: format (b) followed by a switch back to format (a)
  task automatic t_format_b_mix();
    send_byte(8'h84, 1, 0); send_byte(8'h01, 0, 0); send_byte(8'h11, 0, 0);
    send_byte(8'h02, 0, 0); send_byte(8'h22, 0, 0);
    send_byte(8'hA5, 0, 0); send_byte(8'h03, 0, 0); send_byte(8'h33, 0, 0);
    send_end();
    expect_wr(4, 1, 0, 8'h11);
    expect_wr(4, 2, 0, 8'h22);
    expect_wr(5, 3, 1, 8'h33);
    check_writes("R4");
  endtask

  // R3: bytes without a leading row byte are ignored
  task automatic t_idle_ignore();
    send_byte(8'h05, 1, 0); send_byte(8'h10, 0, 0); send_byte(8'h3C, 0, 0);
    send_end();
    check_writes("R3");
    send_byte(8'h06, 1, 0); send_byte(8'h81, 0, 0); send_byte(8'h02, 0, 0);
    send_byte(8'h99, 0, 0);
    send_end();
    expect_wr(1, 2, 0, 8'h99);
    check_writes("R3");
  endtask

  // R5 R6: streaming with column wrap into the next row, data with bit 7 set
  task automatic t_stream();
    send_byte(8'h81, 1, 0); send_byte(8'h5E, 0, 0);
    send_byte(8'hA0, 0, 0); send_byte(8'hA1, 0, 0); send_byte(8'h85, 0, 0);
    send_end();
    expect_wr(1, 30, 0, 8'hA0);
    expect_wr(1, 31, 0, 8'hA1);
    expect_wr(2, 0, 0, 8'h85);
    check_writes("R5");
  endtask

  // R6: row 15 column 31 wraps to row 0 column 0
  task automatic t_row_wrap();
    send_byte(8'hAF, 1, 0); send_byte(8'h5F, 0, 0);
    send_byte(8'h01, 0, 0); send_byte(8'h02, 0, 0);
    send_end();
    expect_wr(15, 31, 1, 8'h01);
    expect_wr(0, 0, 1, 8'h02);
    check_writes("R6");
  endtask

  // R7: last data byte shares its edge with pkt_end
  task automatic t_end_same_cycle();
    send_byte(8'h82, 1, 0); send_byte(8'h03, 0, 0); send_byte(8'h44, 0, 1);
    send_byte(8'h05, 0, 0); send_byte(8'h66, 0, 0);
    go_idle();
    expect_wr(2, 3, 0, 8'h44);
    check_writes("R7");
  endtask

  // R8: pkt_start abandons a packet waiting for data
  task automatic t_start_abandon();
    send_byte(8'h83, 1, 0); send_byte(8'h04, 0, 0);
    send_byte(8'h55, 1, 0);
    send_byte(8'h86, 1, 0); send_byte(8'h07, 0, 0); send_byte(8'h12, 0, 0);
    send_end();
    expect_wr(6, 7, 0, 8'h12);
    check_writes("R8");
  endtask

  // R9: unlocked PLL passes only row 15 columns 15, 17, 18
  task automatic t_lock_filter();
    @(negedge clk); pll_locked = 1'b0;
    send_byte(8'h8F, 1, 0);
    send_byte(8'h0F, 0, 0); send_byte(8'hC1, 0, 0);
    send_byte(8'h10, 0, 0); send_byte(8'hC2, 0, 0);
    send_byte(8'h11, 0, 0); send_byte(8'hC3, 0, 0);
    send_byte(8'h12, 0, 0); send_byte(8'hC4, 0, 0);
    send_byte(8'h8E, 0, 0); send_byte(8'h0F, 0, 0); send_byte(8'hC5, 0, 0);
    send_end();
    send_byte(8'h8F, 1, 0); send_byte(8'h4F, 0, 0);
    send_byte(8'hE0, 0, 0); send_byte(8'hE1, 0, 0);
    send_byte(8'hE2, 0, 0); send_byte(8'hE3, 0, 0);
    send_end();
    @(negedge clk); pll_locked = 1'b1;
    expect_wr(15, 15, 0, 8'hC1);
    expect_wr(15, 17, 0, 8'hC3);
    expect_wr(15, 18, 0, 8'hC4);
    expect_wr(15, 15, 0, 8'hE0);
    expect_wr(15, 17, 0, 8'hE2);
    expect_wr(15, 18, 0, 8'hE3);
    check_writes("R9");
  endtask

  // R10: held write stalls the input; drain and next byte share one edge
  task automatic t_backpressure();
    send_byte(8'h81, 1, 0);
    send_byte(8'h40, 0, 0);
    #1 wr_ready = 1'b0;
    send_byte(8'hD1, 0, 0);
    @(negedge clk);
    in_data = 8'hD2;
    for (int i = 0; i < 3; i++) begin
      check(in_ready == 1'b0, "R10", "in_ready while held", in_ready, 0);
      check(wr_valid == 1'b1 && wr_data == 8'hD1 && wr_col == 5'd0, "R10",
            "held write data", wr_data, 8'hD1);
      @(negedge clk);
    end
    @(posedge clk);
    #1 wr_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    send_end();
    expect_wr(1, 0, 0, 8'hD1);
    expect_wr(1, 1, 0, 8'hD2);
    check_writes("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_format_a();
    t_format_b_mix();
    t_idle_ignore();
    t_stream();
    t_row_wrap();
    t_end_same_cycle();
    t_start_abandon();
    t_lock_filter();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule